// File: doc/BRIEF.md
# Masked-Address GPIO Data Port

This block is a small general-purpose I/O port with eight lines by default. It sits on a simple memory-mapped bus. Writes complete in the cycle the strobe is sampled. Read data is registered and appears the cycle after the strobe. The port holds two registers: a direction register and an output value register. It drives a pad output value and a pad output enable for every line. The pad inputs pass through a two-flop synchroniser before any read sees them.

A data access carries a per-line mask in its word address. Software can therefore read, set or clear any subset of lines in one bus access, with no read-modify-write sequence and no lock around it. A data write changes only lines that are both selected and currently configured as outputs. A write to an input line is dropped. The value of that line must be written again once the line has been turned into an output.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction register and the output value register are all zero. Every pad enable and every pad output is therefore 0, and the read data bus is 0.
- R2: The direction register sits at byte address 0x400 and is read and written as a whole byte. A 1 in bit n makes line n an output, and `pin_oe[n]` follows that bit from the cycle after the write.
- R3: The data region covers byte addresses 0x000 to 0x3FC, and byte address bit n+2 selects line n. A data read returns 0 in every unselected bit. The result appears on `bus_rdata` after the clock edge that samples `bus_rd`, and it holds until the next read.
- R4: A data write changes bit n of the output value register only when line n is selected by the address. Every other bit keeps its value.
- R5: A data write to a line whose direction bit is 0 is discarded. If that line is later switched to output, it drives the value it held before the discarded write.
- R6: For a selected line whose direction bit is 1, a data read returns the value the port drives on that line, not the pad input.
- R7: For a selected input line, a data read returns the pad input through a two-flop synchroniser. Suppose a pad changes before clock edge k. Reads sampled at edges k and k+1 still return the old value, and a read sampled at edge k+2 returns the new one.
- R8: An access at an address above 0x400 is outside the map. A write there changes neither register, and a read there returns 0.
- R9: `pin_out` always equals the output value register, and `pin_oe` always equals the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input values, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The port's state is visible directly at the ports. A wrong direction bit or a wrong output bit shows on `pin_oe` or `pin_out` in the very next cycle. A full-mask read shows the same fault one cycle after the read strobe. A fault in the mask decode or in the input/output select only shows when the read uses a partial mask over mixed directions. The tests therefore combine partial masks with mixed direction patterns and pad values that differ from the driven ones. A synchroniser of the wrong depth only shows in the exact cycle a pad change first becomes readable. Back-to-back reads pin down that cycle.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_DIR  = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_mask_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int ADDR_W    = 12
) (
   input  logic [ADDR_W-1:0]    addr_i,
   output acc_kind_e            kind_o,
   output logic [NUM_LINES-1:0] mask_o
);
   localparam int WORD_W  = ADDR_W - 2;
   localparam int MASK_LO = 2;
   localparam int MASK_HI = NUM_LINES + 1;
   localparam logic [WORD_W-1:0] DIR_WORD = {{(WORD_W-1){1'b0}}, 1'b1} << NUM_LINES;

   logic [WORD_W-1:0] word;
   logic              in_data;

   assign word   = addr_i[ADDR_W-1:2];
   assign mask_o = addr_i[MASK_HI:MASK_LO];

   generate
      if (ADDR_W > NUM_LINES + 2) begin : g_upper
         assign in_data = (addr_i[ADDR_W-1:NUM_LINES+2] == '0);
      end else begin : g_flat
         assign in_data = 1'b1;
      end
   endgenerate

   always_comb begin
      if (in_data)               kind_o = ACC_DATA;
      else if (word == DIR_WORD) kind_o = ACC_DIR;
      else                       kind_o = ACC_NONE;
   end

   initial begin
      assert (ADDR_W >= NUM_LINES + 3)
         else $error("gpio_addr_decode: ADDR_W too small for NUM_LINES");
   end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= async_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];

   initial begin
      assert (STAGES >= 2 && STAGES <= 4)
         else $error("gpio_sync: STAGES must be 2..4");
   end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_data_i,
   input  logic                 wr_dir_i,
   input  logic [NUM_LINES-1:0] sel_i,
   input  logic [NUM_LINES-1:0] wdata_i,
   output logic [NUM_LINES-1:0] dir_q,
   output logic [NUM_LINES-1:0] out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dir_q <= '0;
      else if (wr_dir_i) dir_q <= wdata_i;
   end

   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
         logic take;
         assign take = wr_data_i & sel_i[n] & dir_q[n];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    out_q[n] <= 1'b0;
            else if (take) out_q[n] <= wdata_i[n];
         end
      end
   endgenerate

   AST_DATA_WRITE_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_i |=> (((out_q ^ $past(out_q)) & ~$past(sel_i & dir_q)) == '0)); // R4
   AST_INPUT_LINE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_i |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0)); // R5
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data_i |=> $stable(out_q)); // R4
   AST_DIR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_i |=> (dir_q == $past(wdata_i))); // R2
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir_i |=> $stable(dir_q)); // R2

   initial begin
      assert (NUM_LINES >= 1 && NUM_LINES <= 16)
         else $error("gpio_ctrl_regs: NUM_LINES out of range");
   end
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
   import gpio_mask_pkg::*;
#(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_i,
   input  acc_kind_e            kind_i,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic [NUM_LINES-1:0] dir_i,
   input  logic [NUM_LINES-1:0] out_i,
   input  logic [NUM_LINES-1:0] pin_sync_i,
   output logic [NUM_LINES-1:0] rdata_o
);
   logic [NUM_LINES-1:0] line_val;
   logic [NUM_LINES-1:0] next_rd;

   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_sel
         assign line_val[n] = dir_i[n] ? out_i[n] : pin_sync_i[n];
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         ACC_DATA: next_rd = line_val & mask_i;
         ACC_DIR:  next_rd = dir_i;
         default:  next_rd = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= next_rd;
   end

   AST_RD_UNSELECTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && kind_i == ACC_DATA) |=> ((rdata_o & ~$past(mask_i)) == '0)); // R3
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o)); // R3
   AST_RD_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && kind_i == ACC_NONE) |=> (rdata_o == '0)); // R8
   AST_RD_OUTPUT_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && kind_i == ACC_DATA) |=>
         ((rdata_o & $past(dir_i & mask_i)) == $past(out_i & dir_i & mask_i))); // R6
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int NUM_LINES   = 8,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [NUM_LINES-1:0] bus_wdata,
   output logic [NUM_LINES-1:0] bus_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe
);
   acc_kind_e            kind;
   logic [NUM_LINES-1:0] mask;
   logic [NUM_LINES-1:0] dir_q;
   logic [NUM_LINES-1:0] out_q;
   logic [NUM_LINES-1:0] pin_sync;
   logic                 wr_data;
   logic                 wr_dir;

   gpio_addr_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_dec (
      .addr_i (bus_addr),
      .kind_o (kind),
      .mask_o (mask)
   );

   assign wr_data = bus_wr && (kind == ACC_DATA);
   assign wr_dir  = bus_wr && (kind == ACC_DIR);

   gpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (pin_sync)
   );

   gpio_ctrl_regs #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data_i (wr_data),
      .wr_dir_i  (wr_dir),
      .sel_i     (mask),
      .wdata_i   (bus_wdata),
      .dir_q     (dir_q),
      .out_q     (out_q)
   );

   gpio_rd_path #(.NUM_LINES(NUM_LINES)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_i       (bus_rd),
      .kind_i     (kind),
      .mask_i     (mask),
      .dir_i      (dir_q),
      .out_i      (out_q),
      .pin_sync_i (pin_sync),
      .rdata_o    (bus_rdata)
   );

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   AST_OUTSIDE_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && kind == ACC_NONE) |=> ($stable(pin_out) && $stable(pin_oe))); // R8
   AST_OE_TRACKS_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && kind == ACC_DIR) |=> (pin_oe == $past(bus_wdata))); // R9
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   localparam logic [11:0] DIR_ADDR = 12'h400;

   always #4 clk = ~clk;

   gpio_mask_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic [11:0] data_addr(input logic [7:0] m);
      return {2'b00, m, 2'b00};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1", "pin_oe after reset", pin_oe, 8'h00);
      chk("R1", "pin_out after reset", pin_out, 8'h00);
      chk("R1", "rdata after reset", bus_rdata, 8'h00);
      bus_read(DIR_ADDR, v);
      chk("R1", "direction after reset", v, 8'h00);
   endtask

   task automatic t_dir_rw();
      logic [7:0] v;
      bus_write(DIR_ADDR, 8'hA5);
      chk("R2", "pin_oe after dir write", pin_oe, 8'hA5);
      chk("R9", "pin_oe equals direction", pin_oe, 8'hA5);
      bus_read(DIR_ADDR, v);
      chk("R2", "direction readback", v, 8'hA5);
      bus_write(DIR_ADDR, 8'h3C);
      bus_read(DIR_ADDR, v);
      chk("R2", "direction rewrite", v, 8'h3C);
   endtask

   task automatic t_masked_write();
      logic [7:0] v;
      bus_write(DIR_ADDR, 8'hFF);
      bus_write(data_addr(8'hFF), 8'hFF);
      chk("R9", "pin_out all set", pin_out, 8'hFF);
      bus_write(data_addr(8'h0A), 8'h00);
      chk("R4", "pin_out after masked clear", pin_out, 8'hF5);
      bus_write(data_addr(8'hC0), 8'h40);
      chk("R4", "pin_out after masked mix", pin_out, 8'h75);
      bus_read(data_addr(8'h0F), v);
      chk("R3", "partial mask read", v, 8'h05);
      bus_read(data_addr(8'h00), v);
      chk("R3", "empty mask read", v, 8'h00);
      bus_read(data_addr(8'hFF), v);
      chk("R6", "full read of outputs", v, 8'h75);
   endtask

   task automatic t_input_drop();
      bus_write(data_addr(8'hFF), 8'h00);
      bus_write(DIR_ADDR, 8'h0F);
      bus_write(data_addr(8'hFF), 8'hFF);
      chk("R5", "only output lines take write", pin_out, 8'h0F);
      bus_write(DIR_ADDR, 8'hFF);
      chk("R5", "dropped bits stay after switch", pin_out, 8'h0F);
      bus_write(data_addr(8'hF0), 8'hF0);
      chk("R5", "rewrite after switch", pin_out, 8'hFF);
   endtask

   task automatic t_mixed_read();
      logic [7:0] v;
      bus_write(data_addr(8'hFF), 8'h0F);
      pin_in = 8'hF0;
      repeat (3) @(negedge clk);
      bus_read(data_addr(8'hFF), v);
      chk("R6", "outputs ignore pad", v, 8'h0F);
      bus_write(DIR_ADDR, 8'h33);
      pin_in = 8'hAA;
      repeat (3) @(negedge clk);
      bus_read(data_addr(8'hFF), v);
      chk("R7", "mixed directions read", v, 8'h8B);
      bus_read(data_addr(8'h30), v);
      chk("R3", "mixed directions masked", v, 8'h00);
      bus_read(data_addr(8'h84), v);
      chk("R7", "input lines masked", v, 8'h80);
   endtask

   task automatic t_sync_latency();
      logic [7:0] v0, v1, v2;
      bus_write(DIR_ADDR, 8'h00);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'h5A;
      bus_read(data_addr(8'hFF), v0);
      bus_read(data_addr(8'hFF), v1);
      bus_read(data_addr(8'hFF), v2);
      chk("R7", "read at edge k", v0, 8'h00);
      chk("R7", "read at edge k+1", v1, 8'h00);
      chk("R7", "read at edge k+2", v2, 8'h5A);
   endtask

   task automatic t_outside();
      logic [7:0] v;
      bus_write(DIR_ADDR, 8'h0F);
      bus_write(data_addr(8'hFF), 8'h06);
      bus_write(12'h404, 8'hFF);
      bus_write(12'h800, 8'hFF);
      bus_write(12'hFFC, 8'hFF);
      chk("R8", "pin_oe after outside writes", pin_oe, 8'h0F);
      chk("R8", "pin_out after outside writes", pin_out, 8'h06);
      bus_read(DIR_ADDR, v);
      chk("R8", "direction unchanged", v, 8'h0F);
      pin_in = 8'hFF;
      repeat (3) @(negedge clk);
      bus_read(12'h804, v);
      chk("R8", "outside read is zero", v, 8'h00);
      bus_read(12'hFFC, v);
      chk("R8", "top address read is zero", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dir_rw();
      t_masked_write();
      t_input_drop();
      t_mixed_read();
      t_sync_latency();
      t_outside();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule